// File: doc/BRIEF.md
# DVFS Level Transition Controller

This controller moves a dual-core processor cluster from one of four performance levels to another. Level 0 is the fastest (1000 MHz), followed by level 1 (800 MHz), level 2 (400 MHz) and level 3 (100 MHz). Both cores always run at the same level, so a single instance governs the whole cluster. A request supplies a target level. The controller then runs the supply-rail requests, the clock-divider bank update and the PLL change as a handshaked sequence. The order of that sequence follows the direction of the move.

On a move to a faster level, both rails are raised first, core rail before internal rail. The dividers are updated next, and the PLL change comes last. On a move to a slower level, the PLL change comes first and the dividers second. Both rails are lowered only after the clocks are settled, again core rail first. The PLL step is a full multiplier/divider reprogram when level 0 is the source or the destination. Otherwise only the post-divider (S) field changes. The controller flags that choice to the PLL sequencer.

Each step raises a one-cycle start strobe and then waits for that sub-block's done or acknowledge input. The regulators themselves lie outside this block.

Top module: `dvfs_seq_ctrl`

## Requirements
- R1: After reset the current level is 3, the core-rail code is 72, the internal-rail code is 80, and no strobe, done or error is asserted.
- R2: Voltage codes count 12.5 mV steps. The core code for level L is 96-8*L (1.20 V down to 0.90 V). The internal code is 88 for levels 0 and 1 and 80 for levels 2 and 3. A code changes only in the cycle its rail strobe is raised.
- R3: On a move to a faster level (smaller index), the core-rail strobe is raised, then the internal-rail strobe, each after the previous acknowledge. Both come before any divider or PLL strobe.
- R4: On a move to a slower level, the core-rail and internal-rail strobes, in that order, come only after both clock steps have reported done.
- R5: On a move to a faster level, the divider strobe precedes the PLL strobe.
- R6: On a move to a slower level, the PLL strobe precedes the divider strobe.
- R7: `pll_full_o` is 1 with the PLL strobe when the source or the target is level 0 (full reprogram), and 0 otherwise (S field only).
- R8: A request for the current level gives a one-cycle `done_o` in the cycle after the request, with no strobes.
- R9: A target above 3 gives a one-cycle `err_o`, no strobes and no `done_o`, and leaves the level unchanged.
- R10: A request that arrives while a transition is in progress is ignored.
- R11: At most one start strobe is high in any cycle. `nxt_lvl_o` shows the target while the dividers are started. On completion, `done_o` pulses for one cycle and `cur_lvl_o` takes the target in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Level change request strobe |
| tgt_lvl_i | input | 3 | Requested level; values above 3 are invalid |
| vcore_stb_o | output | 1 | Core-rail voltage request strobe |
| vint_stb_o | output | 1 | Internal-rail voltage request strobe |
| vcore_code_o | output | 8 | Core-rail voltage code |
| vint_code_o | output | 8 | Internal-rail voltage code |
| volt_ack_i | input | 1 | Acknowledge for the pending rail request |
| div_stb_o | output | 1 | Start strobe to the divider-bank updater |
| div_done_i | input | 1 | Divider update finished |
| pll_stb_o | output | 1 | Start strobe to the PLL sequencer |
| pll_full_o | output | 1 | 1: full PLL reprogram, 0: S-field-only change |
| pll_done_i | input | 1 | PLL change finished |
| nxt_lvl_o | output | 2 | Target level of the transition in progress |
| cur_lvl_o | output | 2 | Level currently in force |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle invalid-request pulse |

## Verification
The case hardest to reach from the ports is a second request that arrives mid-transition, while the controller is waiting on a sub-block. The bench plays the voltage, divider and PLL sub-blocks itself and holds each acknowledge back for one to three cycles. On selected transitions it pulses a fresh request with a different target during that wait, then checks that the recorded strobe order, the codes and the final level all belong to the first request. Every one of the sixteen source/target pairs is reached by first driving the controller to the source level.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
    parameter int LVL_N = 4;
    parameter int LVL_W = $clog2(LVL_N);
    parameter int REQ_W = LVL_W + 1;
    parameter int VC_W  = 8;
    parameter int NCH   = 4;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [VC_W-1:0]  vcode_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_VUP_C, ST_VUP_I, ST_CLK1, ST_CLK2, ST_VDN_C, ST_VDN_I
    } seq_st_e;

    typedef struct packed {
        logic bad;
        logic same;
        logic up;
        logic full;
    } plan_t;

    // core rail: 1200 mV minus 100 mV per level, in 12.5 mV units
    function automatic vcode_t core_code(lvl_t l);
        int mv;
        mv = 1200 - 100 * int'(l);
        return vcode_t'((mv * 2) / 25);
    endfunction

    // internal rail: 1100 mV on the two fast levels, 1000 mV otherwise
    function automatic vcode_t int_code(lvl_t l);
        int mv;
        mv = (int'(l) < 2) ? 1100 : 1000;
        return vcode_t'((mv * 2) / 25);
    endfunction
endpackage

// File: rtl/dvfs_route.sv
module dvfs_route
    import dvfs_pkg::*;
(
    input  lvl_t             cur,
    input  logic [REQ_W-1:0] tgt,
    output plan_t            plan
);
    lvl_t tl;
    assign tl = tgt[LVL_W-1:0];

    always_comb begin
        plan.bad  = (int'(tgt) >= LVL_N);
        plan.same = !plan.bad && (tl == cur);
        plan.up   = !plan.bad && (tl < cur);
        plan.full = (tl == '0) || (cur == '0);
    end
endmodule

// File: rtl/dvfs_hs.sv
module dvfs_hs (
    input  logic clk,
    input  logic rst,
    input  logic act,
    input  logic ack,
    output logic stb,
    output logic fin
);
    logic issued;

    assign stb = act && !issued;
    assign fin = act && issued && ack;

    always_ff @(posedge clk) begin
        if (rst || !act) issued <= 1'b0;
        else if (stb)    issued <= 1'b1;
    end

    // R11
    hs_single_chk: assert property (@(posedge clk) disable iff (rst)
        stb |=> !stb);
endmodule

// File: rtl/dvfs_seq_ctrl.sv
module dvfs_seq_ctrl
    import dvfs_pkg::*;
#(
    parameter int INIT_LVL = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_i,
    input  logic [REQ_W-1:0] tgt_lvl_i,
    output logic             vcore_stb_o,
    output logic             vint_stb_o,
    output logic [VC_W-1:0]  vcore_code_o,
    output logic [VC_W-1:0]  vint_code_o,
    input  logic             volt_ack_i,
    output logic             div_stb_o,
    input  logic             div_done_i,
    output logic             pll_stb_o,
    output logic             pll_full_o,
    input  logic             pll_done_i,
    output logic [LVL_W-1:0] nxt_lvl_o,
    output logic [LVL_W-1:0] cur_lvl_o,
    output logic             done_o,
    output logic             err_o
);
    localparam lvl_t RST_LVL = lvl_t'(INIT_LVL);

    seq_st_e st_q, st_d;
    lvl_t    cur_q, tgt_q, tgt_nx;
    logic    up_q, full_q, done_q, err_q;
    vcode_t  vc_q, vi_q;
    plan_t   plan;

    logic [NCH-1:0] act_v, ack_v, stb_v, fin_v;
    logic           clk_fin;

    dvfs_route u_route (.cur(cur_q), .tgt(tgt_lvl_i), .plan(plan));

    // channel order: 0 core rail, 1 internal rail, 2 dividers, 3 PLL
    assign act_v[0] = (st_q == ST_VUP_C) || (st_q == ST_VDN_C);
    assign act_v[1] = (st_q == ST_VUP_I) || (st_q == ST_VDN_I);
    assign act_v[2] = (st_q == ST_CLK1 && up_q) || (st_q == ST_CLK2 && !up_q);
    assign act_v[3] = (st_q == ST_CLK1 && !up_q) || (st_q == ST_CLK2 && up_q);
    assign ack_v    = {pll_done_i, div_done_i, volt_ack_i, volt_ack_i};

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        dvfs_hs u_hs (
            .clk(clk), .rst(rst), .act(act_v[k]), .ack(ack_v[k]),
            .stb(stb_v[k]), .fin(fin_v[k])
        );
    end

    assign clk_fin = fin_v[2] || fin_v[3];
    assign tgt_nx  = (st_q == ST_IDLE) ? tgt_lvl_i[LVL_W-1:0] : tgt_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (req_i && !plan.bad && !plan.same)
                          st_d = plan.up ? ST_VUP_C : ST_CLK1;
            ST_VUP_C: if (fin_v[0]) st_d = ST_VUP_I;
            ST_VUP_I: if (fin_v[1]) st_d = ST_CLK1;
            ST_CLK1:  if (clk_fin)  st_d = ST_CLK2;
            ST_CLK2:  if (clk_fin)  st_d = up_q ? ST_IDLE : ST_VDN_C;
            ST_VDN_C: if (fin_v[0]) st_d = ST_VDN_I;
            ST_VDN_I: if (fin_v[1]) st_d = ST_IDLE;
            default:                st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cur_q  <= RST_LVL;
            tgt_q  <= RST_LVL;
            up_q   <= 1'b0;
            full_q <= 1'b0;
            vc_q   <= core_code(RST_LVL);
            vi_q   <= int_code(RST_LVL);
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (st_q == ST_IDLE && req_i) begin
                if (plan.bad)       err_q  <= 1'b1;
                else if (plan.same) done_q <= 1'b1;
                else begin
                    tgt_q  <= tgt_nx;
                    up_q   <= plan.up;
                    full_q <= plan.full;
                end
            end
            if (st_d != st_q && (st_d == ST_VUP_C || st_d == ST_VDN_C))
                vc_q <= core_code(tgt_nx);
            if (st_d != st_q && (st_d == ST_VUP_I || st_d == ST_VDN_I))
                vi_q <= int_code(tgt_nx);
            if (st_q != ST_IDLE && st_d == ST_IDLE) begin
                done_q <= 1'b1;
                cur_q  <= tgt_q;
            end
        end
    end

    assign vcore_stb_o  = stb_v[0];
    assign vint_stb_o   = stb_v[1];
    assign div_stb_o    = stb_v[2];
    assign pll_stb_o    = stb_v[3];
    assign pll_full_o   = full_q;
    assign vcore_code_o = vc_q;
    assign vint_code_o  = vi_q;
    assign nxt_lvl_o    = tgt_q;
    assign cur_lvl_o    = cur_q;
    assign done_o       = done_q;
    assign err_o        = err_q;

    // R11
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stb_v));

    // R11
    lvl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(cur_lvl_o));

    // R2
    vcore_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(vcore_code_o) |-> vcore_stb_o);

    // R2
    vint_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(vint_code_o) |-> vint_stb_o);

    // R7
    pll_full_chk: assert property (@(posedge clk) disable iff (rst)
        pll_stb_o |-> (pll_full_o == (cur_q == '0 || tgt_q == '0)));

    // R10
    busy_req_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_IDLE && req_i) |=> $stable(tgt_q));

    // R3
    volt_up_chk: assert property (@(posedge clk) disable iff (rst)
        (vcore_stb_o && up_q) |-> (tgt_q < cur_q));
endmodule

// File: tb/sim_dvfs_seq_ctrl.sv
module sim_dvfs_seq_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_i = 1'b0;
    logic [2:0] tgt_i = '0;
    logic       volt_ack = 1'b0, div_done = 1'b0, pll_done = 1'b0;
    logic       vcore_stb, vint_stb, div_stb, pll_stb, pll_full, done, err;
    logic [7:0] vcore_code, vint_code;
    logic [1:0] nxt_lvl, cur_lvl;

    int nchk = 0, nfail = 0, cyc = 0, model_lvl = 3;

    always #5 clk = ~clk;

    dvfs_seq_ctrl u0 (
        .clk(clk), .rst(rst), .req_i(req_i), .tgt_lvl_i(tgt_i),
        .vcore_stb_o(vcore_stb), .vint_stb_o(vint_stb),
        .vcore_code_o(vcore_code), .vint_code_o(vint_code),
        .volt_ack_i(volt_ack), .div_stb_o(div_stb), .div_done_i(div_done),
        .pll_stb_o(pll_stb), .pll_full_o(pll_full), .pll_done_i(pll_done),
        .nxt_lvl_o(nxt_lvl), .cur_lvl_o(cur_lvl), .done_o(done), .err_o(err)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // event kinds: 1 core rail, 2 internal rail, 3 dividers, 4 full PLL, 5 S-field PLL
    task automatic run(input int tgt, input int dly, input bit poke);
        int ek[8]; int ec[8]; int xk[4];
        int nev = 0, nx = 0, cnt = 0, pk = 0, from = model_lvl, f;
        bit gd = 0, ge = 0, up;
        string tg;
        @(negedge clk); req_i = 1'b1; tgt_i = 3'(tgt);
        @(negedge clk); req_i = 1'b0;
        for (int c = 0; c < 400; c++) begin
            volt_ack = 0; div_done = 0; pll_done = 0;
            if (poke && c == 3) begin req_i = 1'b1; tgt_i = 3'((tgt + 1) % 4); end
            else req_i = 1'b0;
            if ($countones({vcore_stb, vint_stb, div_stb, pll_stb}) > 1)
                chk(0, "R11 strobes", $countones({vcore_stb, vint_stb, div_stb, pll_stb}), 1);
            if (nev < 8 && (vcore_stb || vint_stb || div_stb || pll_stb)) begin
                if (vcore_stb)     begin ek[nev] = 1; ec[nev] = vcore_code; pk = 1; end
                else if (vint_stb) begin ek[nev] = 2; ec[nev] = vint_code;  pk = 1; end
                else if (div_stb)  begin ek[nev] = 3; ec[nev] = nxt_lvl;    pk = 2; end
                else               begin ek[nev] = pll_full ? 4 : 5; ec[nev] = 0; pk = 3; end
                nev++; cnt = dly;
            end else if (cnt > 0) begin
                cnt--;
                if (cnt == 0) case (pk)
                    1: volt_ack = 1;
                    2: div_done = 1;
                    default: pll_done = 1;
                endcase
            end
            if (done) gd = 1;
            if (err) ge = 1;
            if (gd || ge) break;
            @(negedge clk);
        end
        req_i = 1'b0; volt_ack = 0; div_done = 0; pll_done = 0;

        up = (tgt < from);
        f  = (tgt == 0 || from == 0) ? 4 : 5;
        if (tgt > 3) begin
            chk(ge && !gd, "R9 err pulse", int'(ge), 1);
        end else if (tgt == from) begin
            chk(gd && !ge, "R8 same-level done", int'(gd), 1);
        end else begin
            if (up) begin xk = '{1, 2, 3, f}; tg = "R3/R5"; end
            else    begin xk = '{f, 3, 1, 2}; tg = "R4/R6"; end
            nx = 4;
            chk(gd, "R11 done pulse", int'(gd), 1);
        end
        chk(nev == nx, (tgt > 3) ? "R9 strobe count" : "R8 strobe count", nev, nx);
        if (poke) chk(nev == nx && gd, "R10 busy request ignored", nev, nx);
        for (int i = 0; i < nx && i < nev; i++) begin
            chk(ek[i] == xk[i], tg, ek[i], xk[i]);
            if (ek[i] >= 4) chk(ek[i] == f, "R7 pll mode", ek[i], f);
            if (ek[i] == 1) chk(ec[i] == 96 - 8 * tgt, "R2 core code", ec[i], 96 - 8 * tgt);
            if (ek[i] == 2) chk(ec[i] == ((tgt < 2) ? 88 : 80), "R2 int code", ec[i], (tgt < 2) ? 88 : 80);
            if (ek[i] == 3) chk(ec[i] == tgt, "R11 nxt_lvl", ec[i], tgt);
        end
        if (tgt <= 3) model_lvl = tgt;
        chk(int'(cur_lvl) == model_lvl, (tgt > 3) ? "R9 level kept" : "R11 level", cur_lvl, model_lvl);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(cur_lvl == 2'd3, "R1 level", cur_lvl, 3);
        chk(vcore_code == 8'd72, "R1 core code", vcore_code, 72);
        chk(vint_code == 8'd80, "R1 int code", vint_code, 80);
        chk({vcore_stb, vint_stb, div_stb, pll_stb, done, err} == '0, "R1 idle outputs",
            {vcore_stb, vint_stb, div_stb, pll_stb, done, err}, 0);
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                if (model_lvl != a) run(a, 1, 1'b0);
                run(b, (a + b) % 3 + 1, (a != b) && ((a + b) % 2 == 1));
            end
        end
        for (int t = 4; t < 8; t++) run(t, 1, 1'b0);
        run(0, 2, 1'b1);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule